// File: doc/BRIEF.md
# XOR Multichannel Output Expander

This block widens a four-word chaotic state stream into up to twenty-six pseudorandom channels. Each accepted beat carries four 32-bit state words (x, y, z, w). A combination network forms the four originals, every pair XOR, every triple XOR, and twelve composite words. A composite word takes one input's upper half XORed with a second input's lower half, then appends a third input's lower half. The channels whose upper bits are statistically weak are cut down to their lower 20 bits before they are registered.

A 26-bit enable register picks which channels are live. It is written through a plain write-enable port. The input side is a valid/ready stream. A beat is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high when the output stage is empty, or when the consumer asserts `out_ready` in the same cycle. While the stage holds a beat and `out_ready` is low, every output stays frozen. The stage counts as occupied even when all enables were off at acceptance, so that beat drains on `out_ready` like any other.

Top module: `xor_chan_expander`

## Requirements
- R1: Channels 0 to 3 carry x, y, z and w in that order, with bit 0 of the channel at bit 0 of the word.
- R2: Channels 4 to 9 carry the pair XORs x^y, x^z, x^w, y^z, y^w and z^w in that order.
- R3: Channels 10 to 13 carry the triple XORs x^y^z, x^y^w, x^z^w and y^z^w in that order.
- R4: Channels 14 to 25 carry composite words of the form {A[31:16]^B[15:0], C[15:0]}. The ordered pairs (A,B) are taken with A ascending and then B ascending, over x=0, y=1, z=2 and w=3 with A≠B. C is the lowest-numbered input that is neither A nor B.
- R5: Channels 0 to 3 and 14 to 21 have bits 31:20 forced to zero. All other channels deliver all 32 bits.
- R6: Bit i of the enable register gates channel i. A disabled channel shows zero data with its valid low. Reset sets all enable bits to one. A write on `cfg_we` takes effect for beats accepted on later cycles.
- R7: A beat accepted at a clock edge appears on `out_data`, with `out_valid` equal to the enable register, directly after that edge: a latency of one cycle.
- R8: `in_ready` equals (stage empty) OR `out_ready`. While the stage is occupied and `out_ready` is low, `out_data` and `out_valid` hold their values.
- R9: After reset, `out_valid` and `out_data` are zero and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept a beat |
| in_x | input | 32 | State word x |
| in_y | input | 32 | State word y |
| in_z | input | 32 | State word z |
| in_w | input | 32 | State word w |
| cfg_we | input | 1 | Write strobe for the enable register |
| cfg_en | input | 26 | Enable value to write |
| out_ready | input | 1 | Consumer accepts the held beat |
| out_valid | output | 26 | Per-channel valid |
| out_data | output | 832 | Channel c at bits [32c+31:32c] |

## Verification
Assertions check on every cycle that a channel with its valid low shows zero data and that the narrow channels never carry upper bits. They also check that a stalled stage freezes both buses and that an accepted beat with any enable set shows a valid one cycle later. Only the bench scenarios can show that each channel holds the right combination in the right position, that the enable written on one cycle applies to later beats, and that the ready rule holds under mixed back-pressure. The bench checks these against a model that it computes from the channel table.

// File: rtl/xme_pkg.sv
package xme_pkg;
  localparam int unsigned NIN    = 4;
  localparam int unsigned NCH    = 26;
  localparam int unsigned WORD   = 32;
  localparam int unsigned HALF   = WORD / 2;
  localparam int unsigned NARROW = 20;
  localparam int unsigned PAIR0  = NIN;
  localparam int unsigned TRIP0  = PAIR0 + 6;
  localparam int unsigned COMP0  = TRIP0 + 4;
  localparam int unsigned COMPN  = 8;

  typedef logic [NIN-1:0][WORD-1:0] src_t;
  typedef logic [NCH-1:0][WORD-1:0] chans_t;

  function automatic logic is_narrow(int unsigned ch);
    return (ch < PAIR0) || ((ch >= COMP0) && (ch < COMP0 + COMPN));
  endfunction

  function automatic logic [WORD-1:0] chan_word(int unsigned ch, src_t v);
    logic [WORD-1:0] r;
    int unsigned k;
    r = '0;
    k = 0;
    if (ch < PAIR0) begin
      r = v[ch];
    end else if (ch < TRIP0) begin
      for (int unsigned a = 0; a < NIN; a++)
        for (int unsigned b = a + 1; b < NIN; b++) begin
          if (k == ch - PAIR0) r = v[a] ^ v[b];
          k++;
        end
    end else if (ch < COMP0) begin
      for (int unsigned o = NIN; o > 0; o--) begin
        if (k == ch - TRIP0) begin
          r = '0;
          for (int unsigned t = 0; t < NIN; t++)
            if (t != o - 1) r = r ^ v[t];
        end
        k++;
      end
    end else begin
      for (int unsigned a = 0; a < NIN; a++)
        for (int unsigned b = 0; b < NIN; b++)
          if (a != b) begin
            if (k == ch - COMP0) begin
              int unsigned c;
              c = 0;
              for (int unsigned t = NIN; t > 0; t--)
                if ((t - 1 != a) && (t - 1 != b)) c = t - 1;
              r = {v[a][WORD-1:HALF] ^ v[b][HALF-1:0], v[c][HALF-1:0]};
            end
            k++;
          end
    end
    return r;
  endfunction
endpackage

// File: rtl/xme_combine.sv
module xme_combine
  import xme_pkg::*;
(
  input  src_t   src,
  output chans_t chans
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_comb chans[c] = chan_word(c, src);
  end
endmodule

// File: rtl/xme_mask.sv
module xme_mask
  import xme_pkg::*;
(
  input  chans_t raw,
  output chans_t trimmed
);
  localparam logic [WORD-1:0] KEEP_NARROW = {{(WORD-NARROW){1'b0}}, {NARROW{1'b1}}};
  localparam logic [WORD-1:0] KEEP_FULL   = '1;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    if (is_narrow(c)) begin : g_narrow
      assign trimmed[c] = raw[c] & KEEP_NARROW;
    end else begin : g_full
      assign trimmed[c] = raw[c] & KEEP_FULL;
    end
  end
endmodule

// File: rtl/xor_chan_expander.sv
module xor_chan_expander
  import xme_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD-1:0]     in_x,
  input  logic [WORD-1:0]     in_y,
  input  logic [WORD-1:0]     in_z,
  input  logic [WORD-1:0]     in_w,
  input  logic                cfg_we,
  input  logic [NCH-1:0]      cfg_en,
  input  logic                out_ready,
  output logic [NCH-1:0]      out_valid,
  output logic [NCH*WORD-1:0] out_data
);
  src_t           src;
  chans_t         raw, trimmed, dat_q;
  logic [NCH-1:0] en_q, vld_q;
  logic           full_q, take;

  assign src = {in_w, in_z, in_y, in_x};

  xme_combine u_combine (.src(src), .chans(raw));
  xme_mask    u_mask    (.raw(raw), .trimmed(trimmed));

  assign in_ready = !full_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '1;
    else if (cfg_we) en_q <= cfg_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      vld_q  <= '0;
      dat_q  <= '0;
    end else if (take) begin
      full_q <= 1'b1;
      vld_q  <= en_q;
      for (int c = 0; c < NCH; c++)
        dat_q[c] <= en_q[c] ? trimmed[c] : '0;
    end else if (out_ready) begin
      full_q <= 1'b0;
      vld_q  <= '0;
      dat_q  <= '0;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_OFF_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid[c] |-> out_data[c*WORD +: WORD] == '0); // R6
    if (is_narrow(c)) begin : g_nar
      AST_NARROW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        out_data[c*WORD+NARROW +: WORD-NARROW] == '0); // R5
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !out_ready) |=> ($stable(out_data) && $stable(out_valid))); // R8

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (|en_q)) |=> (|out_valid)); // R7
endmodule

// File: tb/xor_chan_expander_bench.sv
`timescale 1ns/1ps
module xor_chan_expander_bench;
  localparam int NCH = 26;
  localparam int W   = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, cfg_we = 1'b0, out_ready = 1'b0;
  logic [W-1:0] in_x = '0, in_y = '0, in_z = '0, in_w = '0;
  logic [NCH-1:0] cfg_en = '0;
  logic in_ready;
  logic [NCH-1:0] out_valid;
  logic [NCH*W-1:0] out_data;

  int checks = 0, failures = 0;
  logic done = 1'b0;

  logic m_full = 1'b0;
  logic [NCH-1:0] m_en = '1, m_vld = '0;
  logic [NCH-1:0][W-1:0] m_dat = '0;

  always #2 clk = ~clk;

  xor_chan_expander u_xor_chan_expander (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_z(in_z), .in_w(in_w),
    .cfg_we(cfg_we), .cfg_en(cfg_en), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data));

  function automatic logic [W-1:0] comp(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    return {a[31:16] ^ b[15:0], c[15:0]};
  endfunction

  function automatic logic [W-1:0] expect_ch(int ch, logic [W-1:0] x, logic [W-1:0] y,
                                             logic [W-1:0] z, logic [W-1:0] w);
    logic [W-1:0] r;
    case (ch)
      0: r = x;  1: r = y;  2: r = z;  3: r = w;
      4: r = x ^ y;  5: r = x ^ z;  6: r = x ^ w;
      7: r = y ^ z;  8: r = y ^ w;  9: r = z ^ w;
      10: r = x ^ y ^ z; 11: r = x ^ y ^ w; 12: r = x ^ z ^ w; 13: r = y ^ z ^ w;
      14: r = comp(x, y, z); 15: r = comp(x, z, y); 16: r = comp(x, w, y);
      17: r = comp(y, x, z); 18: r = comp(y, z, x); 19: r = comp(y, w, x);
      20: r = comp(z, x, y); 21: r = comp(z, y, x); 22: r = comp(z, w, x);
      23: r = comp(w, x, y); 24: r = comp(w, y, x); default: r = comp(w, z, x);
    endcase
    if (ch < 4 || (ch >= 14 && ch <= 21)) r = r & 32'h000F_FFFF;
    return r;
  endfunction

  function automatic string req_of(int ch);
    if (ch < 4) return "R1";
    if (ch < 10) return "R2";
    if (ch < 14) return "R3";
    return "R4";
  endfunction

  task automatic check_outputs(string tag);
    checks++;
    if (out_valid !== m_vld) begin
      failures++;
      $display("FAIL %s R7 out_valid actual=%h expected=%h", tag, out_valid, m_vld);
    end
    for (int c = 0; c < NCH; c++) begin
      checks++;
      if (out_data[c*W +: W] !== m_dat[c]) begin
        failures++;
        $display("FAIL %s %s/R5/R6 ch%0d actual=%h expected=%h", tag, req_of(c), c,
                 out_data[c*W +: W], m_dat[c]);
      end
    end
  endtask

  // drive one cycle at negedge, update the model at posedge, compare after it
  task automatic step(logic iv, logic [W-1:0] x, logic [W-1:0] y, logic [W-1:0] z,
                      logic [W-1:0] w, logic ordy, logic we, logic [NCH-1:0] en, string tag);
    logic acc;
    @(negedge clk);
    in_valid = iv; in_x = x; in_y = y; in_z = z; in_w = w;
    out_ready = ordy; cfg_we = we; cfg_en = en;
    #0.5;
    checks++;
    if (in_ready !== (!m_full || ordy)) begin
      failures++;
      $display("FAIL %s R8 in_ready actual=%b expected=%b", tag, in_ready, !m_full || ordy);
    end
    acc = iv && (!m_full || ordy);
    @(posedge clk);
    if (acc) begin
      m_full = 1'b1;
      m_vld = m_en;
      for (int c = 0; c < NCH; c++)
        m_dat[c] = m_en[c] ? expect_ch(c, x, y, z, w) : '0;
    end else if (ordy) begin
      m_full = 1'b0; m_vld = '0; m_dat = '0;
    end
    if (we) m_en = en;
    #1;
    check_outputs(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R9 reset state
    checks++;
    if (in_ready !== 1'b1 || out_valid !== '0 || out_data !== '0) begin
      failures++;
      $display("FAIL R9 reset ready=%b valid=%h actual_nonzero=%b expected ready=1 valid=0",
               in_ready, out_valid, |out_data);
    end
    // directed: distinct patterns for channel mapping (R1..R5)
    step(1, 32'h1111_1111, 32'h2222_2222, 32'h4444_4444, 32'h8888_8888, 1, 0, '0, "map_a");
    step(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, '0, "all_ones");
    step(1, 32'hDEAD_BEEF, 32'h0000_0000, 32'hCAFE_F00D, 32'h1234_5678, 1, 0, '0, "map_b");
    // R6: disable everything, then beat shows zero and no valid
    step(0, '0, '0, '0, '0, 1, 1, '0, "cfg_off");
    step(1, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 1, 0, '0, "all_off");
    // R6: single channel enabled
    step(1, 32'h0BAD_F00D, 32'h1357_9BDF, 32'h2468_ACE0, 32'hFEDC_BA98, 1, 1, 26'h0004000, "one_on");
    step(1, 32'h0BAD_F00D, 32'h1357_9BDF, 32'h2468_ACE0, 32'hFEDC_BA98, 1, 0, '0, "one_on_b");
    step(0, '0, '0, '0, '0, 1, 1, '1, "cfg_all");
    // R8: stall and change inputs and config while held
    step(1, 32'h0123_4567, 32'h89AB_CDEF, 32'h7654_3210, 32'hFEDC_BA98, 0, 0, '0, "fill");
    step(1, 32'hFFFF_0000, 32'h0000_FFFF, 32'h1, 32'h2, 0, 1, 26'h155, "stall1");
    step(1, 32'h3, 32'h4, 32'h5, 32'h6, 0, 0, '0, "stall2");
    step(0, '0, '0, '0, '0, 1, 0, '0, "drain");
    step(0, '0, '0, '0, '0, 1, 1, '1, "restore");
    // random traffic
    for (int i = 0; i < 2000; i++) begin
      logic we;
      logic [NCH-1:0] en;
      we = ($urandom % 16) == 0;
      en = ($urandom % 4 == 0) ? '1 : NCH'($urandom);
      step(($urandom % 4) != 0, $urandom, $urandom, $urandom, $urandom,
           ($urandom % 3) != 0, we, en, "rand");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule